// File: doc/BRIEF.md
# SPI Transfer Buffer and Register Front-End

This block sits between a 16-bit register bus and a serial shift engine. Software or a DMA engine writes words to a data register, and those words queue in a transmit buffer until the engine takes them. Words the engine returns queue in a receive buffer until a read of the same data register pops them. A second data register carries the upper half of each word when the word size is 32 bits.

A two-bit buffer mode picks how deep each side is. The receive side can also hold back transmission while it is full. A status flag records each completed word and drives an interrupt line through a mask. Two DMA request lines report room on the transmit side and waiting data on the receive side. Each line follows one of two policies: it pauses for one cycle after every acknowledge, or it stays up until its buffer is filled or emptied. The engine itself is out of scope. It appears as a valid/ready word output and a single-cycle word-return strobe.

Top module: `spi_fifo_regs`

## Requirements
- R1: After reset, offset 0 reads 0x0000, offset 8 reads 0x0003 (no-buffer mode, priority 0, not busy), and irq, dma_tx_req and dma_rx_req are low.
- R2: Registers sit at byte offsets 0 (control A), 2 (data low), 4 (data high), 6 (interrupt clear) and 8 (control B). Control A holds: bit 0 enable, bits 2:1 word size (0 = 8, 1 = 16, 2 = 32, 3 = 9 bits), bit 3 interrupt mask, bit 4 interrupt status (read-only), bit 5 transmit full (read-only), bits 15:8 engine options. Control B holds: bits 1:0 buffer mode, bit 2 DMA priority, bit 3 busy (read-only). Offset 6 and unmapped offsets read 0.
- R3: While enable reads 1, writes to control A leave the word size and options unchanged, and writes to control B leave the buffer mode unchanged. Enable, mask and priority are always writable. The write that sets enable also loads the other fields when enable was 0.
- R4: A data-low write while enabled queues one word. In 32-bit mode the word is {last data-high write, data-low}; in other modes its upper 16 bits are zero. Words go to the engine in write order through eng_tx_valid/eng_tx_ready.
- R5: The transmit side holds DEPTH words in modes 0 and 2 and one word in modes 1 and 3. Control A bit 5 reads 1 when it is full, and a data-low write at that point is dropped.
- R6: A data-low read pops the oldest received word and returns its low half. Data-high returns the upper half of the most recently popped word without popping. A data-low read with nothing received returns the low half of the last popped word.
- R7: In modes 0 and 1 the receive side holds DEPTH words, and while it is full eng_tx_valid stays low until a read frees space. In modes 2 and 3 it is one word deep, each new word replaces the held one, and transmission never stalls.
- R8: Control B bit 3 reads 1 exactly while a word is offered to the engine (eng_tx_valid high).
- R9: The interrupt status sets on every word returned by the engine. It clears only on a write of any value to offset 6, and reading offset 6 leaves it unchanged. A set and a clear in the same cycle leave it set. irq equals status AND mask.
- R10: dma_tx_req is high while enabled and the transmit side is not full; dma_rx_req is high while enabled and the receive side holds a word. With priority 0 a request is low in the cycle after its acknowledge; with priority 1 an acknowledge has no effect.
- R11: While enable is 0 both buffers are emptied, the interrupt status is cleared, and data writes and engine words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on data low) |
| bus_addr | input | 4 | Byte offset |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data, combinational from address |
| irq | output | 1 | Masked interrupt |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_tx_ack | input | 1 | Transmit DMA acknowledge |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_rx_ack | input | 1 | Receive DMA acknowledge |
| eng_tx_valid | output | 1 | Word offered to engine |
| eng_tx_ready | input | 1 | Engine takes the offered word |
| eng_tx_data | output | 2*REG_W | Offered word |
| eng_rx_valid | input | 1 | Engine returns a word (one cycle) |
| eng_rx_data | input | 2*REG_W | Returned word |
| eng_word_size | output | 2 | Word size to engine |
| eng_opts | output | 8 | Option bits to engine |

## Verification
Two of the block's functions can land on the same clock edge: a bus write to the interrupt-clear offset and the engine's word-return strobe. The bench starts both tasks from the same falling edge so they hit one rising edge, then expects irq to stay high, since the set must win. A similar collision is the receive-side stall, which is provoked by returning DEPTH words and then queuing a transmit word. eng_tx_valid is then judged low until a single data-low read frees one slot.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  localparam logic [3:0] OFS_CTLA = 4'h0;
  localparam logic [3:0] OFS_DLO  = 4'h2;
  localparam logic [3:0] OFS_DHI  = 4'h4;
  localparam logic [3:0] OFS_ICLR = 4'h6;
  localparam logic [3:0] OFS_CTLB = 4'h8;

  typedef enum logic [1:0] {
    BM_BOTH    = 2'd0,
    BM_RX_DEEP = 2'd1,
    BM_TX_DEEP = 2'd2,
    BM_NONE    = 2'd3
  } buf_mode_e;

  typedef enum logic [1:0] {
    WS_8  = 2'd0,
    WS_16 = 2'd1,
    WS_32 = 2'd2,
    WS_9  = 2'd3
  } word_size_e;

  function automatic logic tx_is_deep(buf_mode_e m);
    return (m == BM_BOTH) || (m == BM_TX_DEEP);
  endfunction

  function automatic logic rx_is_deep(buf_mode_e m);
    return (m == BM_BOTH) || (m == BM_RX_DEEP);
  endfunction

  function automatic logic [31:0] build_word(word_size_e ws, logic [15:0] hi, logic [15:0] lo);
    return (ws == WS_32) ? {hi, lo} : {16'h0000, lo};
  endfunction

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         single,
  input  logic         overwrite,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] cap;
  logic             do_pop, do_push, drop_old, advance_rd;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap        = single ? CNT_W'(1) : CNT_W'(DEPTH);
  assign empty      = (count_q == '0);
  assign full       = (count_q >= cap);
  assign do_pop     = pop && !empty;
  assign do_push    = push && (!full || do_pop || overwrite);
  assign drop_old   = push && full && overwrite && !do_pop;
  assign advance_rd = do_pop || drop_old;
  assign head       = mem_q[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem_q[wr_ptr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push)    wr_ptr_q <= bump(wr_ptr_q);
      if (advance_rd) rd_ptr_q <= bump(rd_ptr_q);
      case ({do_push, advance_rd})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R5
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !overwrite && !pop && !flush) |=> $stable(count_q));

endmodule

// File: rtl/spi_dma_gate.sv
module spi_dma_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic ack,
  input  logic hold_prio,
  output logic req
);
  logic gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= 1'b0;
    else        gap_q <= ack && !hold_prio;
  end

  assign req = want && (hold_prio || !gap_q);

  // R10
  ack_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hold_prio) |=> !req);

endmodule

// File: rtl/spi_fifo_regs.sv
module spi_fifo_regs
  import spi_fifo_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [3:0]         bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               irq,
  output logic               dma_tx_req,
  input  logic               dma_tx_ack,
  output logic               dma_rx_req,
  input  logic               dma_rx_ack,
  output logic               eng_tx_valid,
  input  logic               eng_tx_ready,
  output logic [2*REG_W-1:0] eng_tx_data,
  input  logic               eng_rx_valid,
  input  logic [2*REG_W-1:0] eng_rx_data,
  output logic [1:0]         eng_word_size,
  output logic [7:0]         eng_opts
);
  localparam int DW      = 2 * REG_W;
  localparam int NUM_DMA = 2;

  logic          en_q, mask_q, prio_q, int_q;
  word_size_e    word_q;
  buf_mode_e     mode_q;
  logic [7:0]    opts_q;
  logic [REG_W-1:0] hi_stage_q;
  logic [DW-1:0] last_rd_q;

  // named internal events
  logic wr_ctla, wr_ctlb, wr_dlo, wr_dhi, wr_iclr, rd_dlo;
  logic tx_push, tx_pop, rx_push, rx_pop, int_set, stall;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic [DW-1:0] tx_head, rx_head;
  logic [NUM_DMA-1:0] dma_want, dma_ack, dma_req;

  assign wr_ctla = bus_wr && (bus_addr == OFS_CTLA);
  assign wr_ctlb = bus_wr && (bus_addr == OFS_CTLB);
  assign wr_dlo  = bus_wr && (bus_addr == OFS_DLO);
  assign wr_dhi  = bus_wr && (bus_addr == OFS_DHI);
  assign wr_iclr = bus_wr && (bus_addr == OFS_ICLR);
  assign rd_dlo  = bus_rd && (bus_addr == OFS_DLO);

  assign tx_push      = wr_dlo && en_q;
  assign rx_push      = eng_rx_valid && en_q;
  assign rx_pop       = rd_dlo;
  assign int_set      = rx_push;
  assign stall        = rx_is_deep(mode_q) && rx_full;
  assign eng_tx_valid = en_q && !tx_empty && !stall;
  assign tx_pop       = eng_tx_valid && eng_tx_ready;
  assign eng_tx_data  = tx_head;

  spi_word_fifo #(.W(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!en_q),
    .single(!tx_is_deep(mode_q)), .overwrite(1'b0),
    .push(tx_push), .wdata(build_word(word_q, hi_stage_q, bus_wdata)),
    .pop(tx_pop), .head(tx_head), .empty(tx_empty), .full(tx_full)
  );

  spi_word_fifo #(.W(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!en_q),
    .single(!rx_is_deep(mode_q)), .overwrite(!rx_is_deep(mode_q)),
    .push(rx_push), .wdata(eng_rx_data),
    .pop(rx_pop), .head(rx_head), .empty(rx_empty), .full(rx_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      mask_q     <= 1'b0;
      word_q     <= WS_8;
      opts_q     <= '0;
      mode_q     <= BM_NONE;
      prio_q     <= 1'b0;
      int_q      <= 1'b0;
      hi_stage_q <= '0;
      last_rd_q  <= '0;
    end else begin
      if (wr_ctla) begin
        en_q   <= bus_wdata[0];
        mask_q <= bus_wdata[3];
        if (!en_q) begin
          word_q <= word_size_e'(bus_wdata[2:1]);
          opts_q <= bus_wdata[15:8];
        end
      end
      if (wr_ctlb) begin
        prio_q <= bus_wdata[2];
        if (!en_q) mode_q <= buf_mode_e'(bus_wdata[1:0]);
      end
      if (wr_dhi) hi_stage_q <= bus_wdata;
      if (rx_pop && !rx_empty) last_rd_q <= rx_head;
      if (!en_q)        int_q <= 1'b0;
      else if (int_set) int_q <= 1'b1;
      else if (wr_iclr) int_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_CTLA: bus_rdata = {opts_q, 2'b00, tx_full, int_q, mask_q, word_q, en_q};
      OFS_DLO:  bus_rdata = rx_empty ? last_rd_q[REG_W-1:0] : rx_head[REG_W-1:0];
      OFS_DHI:  bus_rdata = last_rd_q[DW-1:REG_W];
      OFS_CTLB: bus_rdata = {{(REG_W-4){1'b0}}, eng_tx_valid, prio_q, mode_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign dma_want = {en_q && !rx_empty, en_q && !tx_full};
  assign dma_ack  = {dma_rx_ack, dma_tx_ack};

  for (genvar gi = 0; gi < NUM_DMA; gi++) begin : g_dma
    spi_dma_gate u_gate (
      .clk(clk), .rst_n(rst_n), .want(dma_want[gi]), .ack(dma_ack[gi]),
      .hold_prio(prio_q), .req(dma_req[gi])
    );
  end

  assign dma_tx_req    = dma_req[0];
  assign dma_rx_req    = dma_req[1];
  assign irq           = int_q && mask_q;
  assign eng_word_size = word_q;
  assign eng_opts      = opts_q;

  // R9
  int_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_set |=> int_q);
  // R9
  int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_iclr && !int_set) |=> !int_q);
  // R7
  rx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_is_deep(mode_q) && rx_full) |-> !eng_tx_valid);
  // R11
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (tx_empty && rx_empty && !int_q));

endmodule

// File: tb/spi_fifo_regs_bench.sv
module spi_fifo_regs_bench;
  import spi_fifo_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, dma_tx_req, dma_rx_req;
  logic        dma_tx_ack = 1'b0, dma_rx_ack = 1'b0;
  logic        eng_tx_valid;
  logic        eng_tx_ready = 1'b0;
  logic [31:0] eng_tx_data;
  logic        eng_rx_valid = 1'b0;
  logic [31:0] eng_rx_data = '0;
  logic [1:0]  eng_word_size;
  logic [7:0]  eng_opts;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] tx_q [$];

  always #5 clk = ~clk;

  spi_fifo_regs u_spi_fifo_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .dma_tx_req(dma_tx_req), .dma_tx_ack(dma_tx_ack),
    .dma_rx_req(dma_rx_req), .dma_rx_ack(dma_rx_ack),
    .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready),
    .eng_tx_data(eng_tx_data), .eng_rx_valid(eng_rx_valid),
    .eng_rx_data(eng_rx_data), .eng_word_size(eng_word_size), .eng_opts(eng_opts)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // driver: queue a transmit word and its expected engine-side value
  task automatic send(logic [15:0] lo, logic [31:0] exp);
    wr(OFS_DLO, lo);
    tx_q.push_back(exp);
  endtask

  task automatic deliver(logic [31:0] d);
    @(negedge clk);
    eng_rx_data = d; eng_rx_valid = 1'b1;
    @(negedge clk);
    eng_rx_valid = 1'b0;
  endtask

  task automatic drain(int n);
    @(negedge clk);
    eng_tx_ready = 1'b1;
    repeat (n) @(negedge clk);
    eng_tx_ready = 1'b0;
  endtask

  // monitor: compare each word taken by the engine against the scoreboard
  always @(negedge clk) begin
    #2;
    if (rst_n && eng_tx_valid && eng_tx_ready) begin
      if (tx_q.size() == 0) chk("R4 unexpected word", eng_tx_data, 32'hxxxx_xxxx);
      else chk("R4 order", eng_tx_data, tx_q.pop_front());
    end
  end

  task automatic run();
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(OFS_CTLA, v); chk("R1 ctla", 32'(v), 32'h0000);
    peek(OFS_CTLB, v); chk("R1 ctlb", 32'(v), 32'h0003);
    chk("R1 outs", {29'd0, irq, dma_tx_req, dma_rx_req}, 32'd0);
    peek(OFS_ICLR, v); chk("R2 iclr reads 0", 32'(v), 32'h0000);

    // mode 0, 32-bit words, mask on
    wr(OFS_CTLB, 16'h0000);
    wr(OFS_CTLA, 16'hAB0C);
    peek(OFS_CTLA, v); chk("R2 ctla layout", 32'(v), 32'h0000AB0C);
    chk("R2 engine cfg", {22'd0, eng_word_size, eng_opts}, {22'd0, 2'd2, 8'hAB});
    wr(OFS_CTLA, 16'hAB0D);
    wr(OFS_CTLA, 16'h1203);
    peek(OFS_CTLA, v); chk("R3 ctla frozen", 32'(v), 32'h0000AB05);
    wr(OFS_CTLA, 16'hAB0D);
    wr(OFS_CTLB, 16'h0003);
    peek(OFS_CTLB, v); chk("R3 mode frozen", 32'(v), 32'h0000);
    chk("R10 tx req idle", 32'(dma_tx_req), 32'd1);
    chk("R10 rx req idle", 32'(dma_rx_req), 32'd0);

    // fill the transmit side
    wr(OFS_DHI, 16'hAAAA);
    for (int i = 1; i <= 4; i++) send(16'(i), {16'hAAAA, 16'(i)});
    peek(OFS_CTLA, v); chk("R5 full flag", 32'(v), 32'h0000AB2D);
    chk("R10 tx req when full", 32'(dma_tx_req), 32'd0);
    peek(OFS_CTLB, v); chk("R8 busy", 32'(v), 32'h0008);
    wr(OFS_DLO, 16'h0055);
    drain(6);
    chk("R5 drop left queue empty", 32'(tx_q.size()), 32'd0);
    chk("R4 nothing offered", 32'(eng_tx_valid), 32'd0);

    // fill the receive side, then stall
    for (int i = 1; i <= 4; i++) begin
      deliver({16'h1111, 16'(i)});
      if (i == 1) chk("R9 irq on word", 32'(irq), 32'd1);
    end
    send(16'h0077, 32'hAAAA0077);
    chk("R7 stalled", 32'(eng_tx_valid), 32'd0);
    peek(OFS_CTLB, v); chk("R8 not busy stalled", 32'(v), 32'h0000);
    rd(OFS_DLO, v); chk("R6 pop low", 32'(v), 32'h0001);
    rd(OFS_DHI, v); chk("R6 high of popped", 32'(v), 32'h1111);
    chk("R7 released", 32'(eng_tx_valid), 32'd1);
    peek(OFS_CTLB, v); chk("R8 busy again", 32'(v), 32'h0008);
    drain(1);

    // DMA policies on the receive request
    @(negedge clk); dma_rx_ack = 1'b1;
    @(negedge clk); dma_rx_ack = 1'b0;
    #1 chk("R10 low-prio pause", 32'(dma_rx_req), 32'd0);
    @(negedge clk);
    #1 chk("R10 low-prio resume", 32'(dma_rx_req), 32'd1);
    wr(OFS_CTLB, 16'h0004);
    peek(OFS_CTLB, v); chk("R3 prio writable", 32'(v), 32'h0004);
    @(negedge clk); dma_rx_ack = 1'b1;
    @(negedge clk); dma_rx_ack = 1'b0;
    #1 chk("R10 high-prio hold", 32'(dma_rx_req), 32'd1);
    for (int i = 2; i <= 4; i++) begin
      rd(OFS_DLO, v); chk("R6 pop order", 32'(v), 32'(i));
    end
    chk("R10 rx req emptied", 32'(dma_rx_req), 32'd0);
    rd(OFS_DLO, v); chk("R6 empty read", 32'(v), 32'h0004);

    // interrupt clear
    rd(OFS_ICLR, v); chk("R2 iclr read 0", 32'(v), 32'h0000);
    chk("R9 read keeps irq", 32'(irq), 32'd1);
    wr(OFS_ICLR, 16'h5A5A);
    chk("R9 clear", 32'(irq), 32'd0);
    fork
      wr(OFS_ICLR, 16'h0000);
      deliver(32'h2222_0009);
    join
    chk("R9 set wins", 32'(irq), 32'd1);
    wr(OFS_CTLA, 16'hAB05);
    chk("R9 masked", 32'(irq), 32'd0);
    peek(OFS_CTLA, v); chk("R9 status kept", 32'(v), 32'h0000AB15);

    // disable flushes
    wr(OFS_DLO, 16'h0099);
    wr(OFS_CTLA, 16'hAB04);
    @(negedge clk);
    peek(OFS_CTLA, v); chk("R11 cleared", 32'(v), 32'h0000AB04);
    rd(OFS_DLO, v); chk("R11 rx flushed", 32'(v), 32'h0004);
    chk("R11 tx flushed", {30'd0, eng_tx_valid, dma_rx_req}, 32'd0);
    deliver(32'h0000_0003);
    wr(OFS_DLO, 16'h1234);
    peek(OFS_CTLA, v); chk("R11 word ignored", 32'(v), 32'h0000AB04);

    // mode 3, 16-bit words
    wr(OFS_CTLB, 16'h0003);
    wr(OFS_CTLA, 16'h000B);
    chk("R11 write ignored", 32'(eng_tx_valid), 32'd0);
    peek(OFS_CTLB, v); chk("R2 mode 3", 32'(v), 32'h0003);
    send(16'h00C1, 32'h0000_00C1);
    peek(OFS_CTLA, v); chk("R5 single full", 32'(v), 32'h002B);
    wr(OFS_DLO, 16'h00C2);
    deliver(32'h0000_0A01);
    deliver(32'h0000_0A02);
    chk("R7 no stall", 32'(eng_tx_valid), 32'd1);
    rd(OFS_DLO, v); chk("R7 overwrite", 32'(v), 32'h0A02);
    drain(3);
    chk("R4 queue drained", 32'(tx_q.size()), 32'd0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule